// File: doc/BRIEF.md
# Auto-Increment Palette Lookup RAM

This block is a 256-entry colour lookup table. It sits between a byte-wide host register port and a pixel stream. To load colours, the host writes a starting entry number to the index register. It then sends colour bytes one after another to a single data register. An internal three-step counter sends each byte to the red, green or blue field of the current entry. After the blue byte, the index moves on to the next entry, so a whole palette can be loaded as one uninterrupted stream of bytes.

On the pixel side, each incoming pixel index is ANDed with a host-programmable mask before it addresses the table. The selected entry is presented one clock later as 8-bit red, green and blue outputs. A control bit selects how the components are interpreted:

- **8-bit mode:** components pass through unchanged.
- **6-bit mode:** each component's low six bits are widened to 8 bits by copying their top bits into the vacated low bits.

Top module: `palette_lut`

## Requirements
- R1: A host write to register address 0 loads the write index from the data byte and returns the component counter to red.
- R2: Host writes to register address 1 store the byte into red, then green, then blue of the entry at the write index, in that order.
- R3: The write after green (the blue write) increments the write index by one and returns the counter to red; index 255 increments to 0.
- R4: A host read strobe at register address 0 returns the component counter to red without changing the write index.
- R5: A host write to register address 2 loads the pixel mask. The pixel index is ANDed bitwise with the mask before lookup. The mask resets to 0xFF, which passes every bit.
- R6: Bit 0 of a host write to register address 3 selects the component mode. With the bit set (8-bit mode), stored components are output unchanged. With the bit clear (6-bit mode, the reset state), stored component c is output as {c[5:0], c[5:4]}.
- R7: The colour outputs present the entry selected by the pixel index sampled at the previous clock edge. A data write is visible to a lookup that is sampled at the next edge.
- R8: While reset is asserted, the colour outputs are zero, the write index is 0 and the counter is at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 index, 1 data, 2 mask, 3 control |
| host_wdata | input | 8 | Host write data |
| pix_idx | input | 8 | Pixel colour index |
| pix_r | output | 8 | Red output |
| pix_g | output | 8 | Green output |
| pix_b | output | 8 | Blue output |

## Verification
The assertions assume that the host never raises the write and read strobes in the same cycle. They also assume that strobes carry meaningful values only outside reset. The bench issues host operations one per cycle through tasks that raise exactly one strobe. It also never issues a lookup in the same cycle as a host write, and it looks up only entries it has already written, so no uninitialised table contents reach a comparison.

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [7:0]       host_wdata,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [CW-1:0]    pix_r,
  output logic [CW-1:0]    pix_g,
  output logic [CW-1:0]    pix_b
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] A_IDX  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [IDX_W-1:0] widx;
  logic [1:0]       phase;
  logic [IDX_W-1:0] mask;
  logic             mode8;

  logic [CW-1:0] lut_r [DEPTH];
  logic [CW-1:0] lut_g [DEPTH];
  logic [CW-1:0] lut_b [DEPTH];

  wire data_wr = host_wr && host_addr == A_DATA;
  wire last_c  = phase == 2'd2;
  wire [IDX_W-1:0] look = pix_idx & mask;

  function automatic logic [CW-1:0] widen(input logic [CW-1:0] c, input logic full);
    return full ? c : {c[CW-3:0], c[CW-3:CW-4]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx  <= '0;
      phase <= 2'd0;
      mask  <= '1;
      mode8 <= 1'b0;
    end else if (host_wr) begin
      case (host_addr)
        A_IDX: begin
          widx  <= host_wdata[IDX_W-1:0];
          phase <= 2'd0;
        end
        A_DATA: begin
          phase <= last_c ? 2'd0 : phase + 2'd1;
          if (last_c) widx <= widx + 1'b1;
        end
        A_MASK: mask  <= host_wdata[IDX_W-1:0];
        default: mode8 <= host_wdata[0];
      endcase
    end else if (host_rd && host_addr == A_IDX) begin
      phase <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) begin
      case (phase)
        2'd0:    lut_r[widx] <= host_wdata[CW-1:0];
        2'd1:    lut_g[widx] <= host_wdata[CW-1:0];
        default: lut_b[widx] <= host_wdata[CW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_r <= '0;
      pix_g <= '0;
      pix_b <= '0;
    end else begin
      pix_r <= widen(lut_r[look], mode8);
      pix_g <= widen(lut_g[look], mode8);
      pix_b <= widen(lut_b[look], mode8);
    end
  end
endmodule

module palette_lut_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_addr,
  input logic [7:0]       host_wdata,
  input logic [IDX_W-1:0] widx,
  input logic [1:0]       phase,
  input logic [IDX_W-1:0] mask
);
  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0) |=> (widx == $past(host_wdata[IDX_W-1:0]) && phase == 2'd0));

  // R2
  comp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && phase != 2'd2) |=> (phase == $past(phase) + 2'd1 && $stable(widx)));

  // R3
  idx_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && phase == 2'd2) |=> (widx == $past(widx) + 1'b1 && phase == 2'd0));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && host_rd && host_addr == 2'd0) |=> (phase == 2'd0 && $stable(widx)));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd2) |=> mask == $past(host_wdata[IDX_W-1:0]));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
endmodule

bind palette_lut palette_lut_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata),
  .widx(widx), .phase(phase), .mask(mask)
);

// File: tb/test_palette_lut.sv
module test_palette_lut;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] pix_idx = 0;
  logic [7:0] pix_r, pix_g, pix_b;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx = 0, m_mask = 8'hFF;
  int         m_ph = 0;
  bit         m_full = 0;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  palette_lut i_palette_lut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .pix_idx(pix_idx),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  function automatic logic [7:0] wid(input logic [7:0] c);
    return m_full ? c : {c[5:0], c[5:4]};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    case (a)
      2'd0: begin m_idx = d; m_ph = 0; end
      2'd1: begin
        if (m_ph == 0) m_r[m_idx] = d;
        else if (m_ph == 1) m_g[m_idx] = d;
        else m_b[m_idx] = d;
        if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
        else m_ph++;
      end
      2'd2: m_mask = d;
      default: m_full = d[0];
    endcase
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic rd_idx();
    @(negedge clk);
    host_rd = 1; host_addr = 2'd0; m_ph = 0;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic look(input logic [7:0] idx, input string req);
    logic [7:0] e;
    @(negedge clk);
    pix_idx = idx;
    e = idx & m_mask;
    exp_q.push_back({wid(m_r[e]), wid(m_g[e]), wid(m_b[e])});
    tag_q.push_back(req);
    @(posedge clk);
  endtask

  initial forever begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), {pix_r, pix_g, pix_b}, exp_q.pop_front());
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R8", {pix_r, pix_g, pix_b}, 24'h0);
    @(negedge clk); rst_n = 1;

    // R1 R2 R5 R6: reset mask passes all bits, 6-bit mode widening
    wr(2'd0, 8'hA5); wr(2'd1, 8'h41); wr(2'd1, 8'h82); wr(2'd1, 8'hC3);
    look(8'hA5, "R6");
    check("R6", {wid(8'h41), wid(8'h82), wid(8'hC3)}, 24'h04080C);
    wr(2'd3, 8'h01);
    look(8'hA5, "R2");

    // R3 auto-increment over a triple boundary
    wr(2'd0, 8'h10);
    for (int i = 0; i < 6; i++) wr(2'd1, 8'h20 + 8'(i));
    look(8'h10, "R3"); look(8'h11, "R3");

    // R3 wrap 255 -> 0
    wr(2'd0, 8'hFF);
    for (int i = 0; i < 6; i++) wr(2'd1, 8'h90 + 8'(i));
    look(8'hFF, "R3"); look(8'h00, "R3");

    // R4 read of index register restarts at red
    wr(2'd0, 8'h21); wr(2'd1, 8'h11); wr(2'd1, 8'h12); wr(2'd1, 8'h13);
    wr(2'd0, 8'h20); wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    rd_idx();
    wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
    look(8'h20, "R4"); look(8'h21, "R4");

    // R1 index write mid-triple resets the counter
    wr(2'd0, 8'h30); wr(2'd1, 8'h55); wr(2'd1, 8'h56); wr(2'd1, 8'h57);
    wr(2'd0, 8'h30); wr(2'd1, 8'h77);
    wr(2'd0, 8'h40); wr(2'd1, 8'h61); wr(2'd1, 8'h62); wr(2'd1, 8'h63);
    look(8'h30, "R1"); look(8'h40, "R1");

    // R5 mask gating
    wr(2'd0, 8'h05); wr(2'd1, 8'hE1); wr(2'd1, 8'hE2); wr(2'd1, 8'hE3);
    wr(2'd2, 8'h0F);
    look(8'hA5, "R5");
    wr(2'd2, 8'h00);
    look(8'h5A, "R5");
    wr(2'd2, 8'hFF);

    // R7 write seen by the very next lookup, one-cycle latency
    wr(2'd0, 8'h77); wr(2'd1, 8'h0A); wr(2'd1, 8'h0B); wr(2'd1, 8'h0C);
    look(8'h77, "R7");
    look(8'h10, "R7");
    look(8'h77, "R7");

    // R6 back to 6-bit mode
    wr(2'd3, 8'h00);
    look(8'h40, "R6");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule